// File: doc/BRIEF.md
# Instruction Byte Queue with Length Splitter

This block sits between instruction fetch and decode. Each cycle the fetch side may offer one wide block of instruction bytes, 48 bytes by default. The queue keeps these bytes in program order and cuts them into individual instructions. The only decoding it does is to find each instruction's length. Up to six complete instructions per cycle are presented to the decoder, each with its address and a size flag.

Two modes are supported, selected by `cmp_mode`:

- **Fixed mode** (`cmp_mode` = 0): every instruction is 32 bits.
- **Compressed mode** (`cmp_mode` = 1): 16-bit and 32-bit instructions are mixed. A 32-bit instruction may start on any halfword and may straddle two fetch blocks. Its leading halfword is then held until the rest arrives.

When the queue cannot take another full block, `fetch_ready` goes low. Fetch is then gated until decode has drained enough room. A redirect pulses `flush`. This empties the queue in one cycle and loads the address of the new stream. The first block accepted after the flush may skip a number of leading halfwords, so that the stream can start in the middle of a block.

Top module: `insn_byte_queue`

## Requirements
- R1: After reset, no decode slot is valid, `fetch_ready` is high, and the stream address is 0. The first accepted block obeys the skip rule of R10.
- R2: In fixed mode, every instruction is two consecutive halfwords. The output word holds the earlier halfword in bits 15:0 and the later halfword in bits 31:16, and `dec_wide` is 1. Halfword k of a fetch block is bytes 2k (bits 7:0) and 2k+1 (bits 15:8).
- R3: In compressed mode, a leading halfword whose bits 15:11 are 11101, 11110 or 11111 starts a 32-bit instruction, packed as in R2 with `dec_wide` = 1. Any other leading halfword is a whole 16-bit instruction, output in bits 15:0 with bits 31:16 zero and `dec_wide` = 0.
- R4: An instruction is presented only when all of its halfwords are stored. A 32-bit instruction split across two fetch blocks is joined once the second block arrives.
- R5: Valid slots are always slot 0 upward with no gaps. Each slot's address is the head address plus 2 for every stored halfword ahead of it.
- R6: Up to six instructions are presented at once. When `dec_ready` is high, all presented instructions are consumed at the clock edge, and the next instruction moves to slot 0.
- R7: `fetch_ready` is high exactly when the stored halfword count is at most the capacity minus one block. A block offered with `fetch_valid` and `fetch_ready` both high is appended.
- R8: While `dec_ready` is low and no flush occurs, nothing is consumed and the presented slots stay unchanged.
- R9: A cycle with `flush` high discards any write or consumption in that cycle. On the next cycle the queue is empty with `fetch_ready` high.
- R10: The first block accepted after reset or a flush drops its first `fetch_ofs` halfwords, and its first kept halfword has address `redirect_pc` (0 after reset). Later blocks are used in full and `fetch_ofs` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous redirect: empty the queue |
| redirect_pc | input | 32 | New stream address, taken when flush is high |
| cmp_mode | input | 1 | 1 = mixed 16/32-bit, 0 = fixed 32-bit |
| fetch_valid | input | 1 | Fetch block offered |
| fetch_ready | output | 1 | Queue can accept a full block |
| fetch_bytes | input | 384 | Fetch block, byte 0 in bits 7:0 |
| fetch_ofs | input | 5 | Leading halfwords to skip in the first block after a flush |
| dec_ready | input | 1 | Decoder takes every presented slot |
| dec_valid | output | 6 | Per-slot valid |
| dec_insn | output | 192 | Per-slot instruction word, slot s in bits 32s+31:32s |
| dec_addr | output | 192 | Per-slot instruction address |
| dec_wide | output | 6 | Per-slot size flag, 1 = 32-bit |

## Verification
A wrong halfword count or a wrong head pointer shows up at once as a wrong slot 0 address or instruction word, on the first cycle after the faulty update. A wrong length decision shifts every later slot in that same cycle, so the error appears without delay. Errors in how much room is left show up one cycle later, as `fetch_ready` disagreeing with the occupancy that follows from the stream accepted and consumed so far. A bad skip count after a redirect is visible in the first slot presented after the first accepted block.

// File: rtl/ibq_pkg.sv
package ibq_pkg;
  localparam int PC_W = 32;
  localparam int HW_W = 16;

  typedef logic [HW_W-1:0] hword_t;

  // leading halfword of a 32-bit instruction; every instruction is wide in fixed mode
  function automatic logic starts_wide(input logic cmp_mode, input hword_t h);
    return !cmp_mode || (h[15:11] == 5'b11101) || (h[15:12] == 4'b1111);
  endfunction
endpackage

// File: rtl/ibq_store.sv
module ibq_store
  import ibq_pkg::*;
#(
  parameter int QHW  = 48,
  parameter int FHW  = 24,
  parameter int CNTW = $clog2(QHW + 1),
  parameter int FIW  = $clog2(FHW)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [PC_W-1:0]       redirect_pc,
  input  logic                  wr_en,
  input  hword_t [FHW-1:0]      wr_hw,
  input  logic [FIW-1:0]        wr_ofs,
  input  logic [CNTW-1:0]       cons,
  output hword_t [QHW-1:0]      hw_o,
  output logic [CNTW-1:0]       cnt_o,
  output logic [PC_W-1:0]       pc_o,
  output logic                  room_o
);
  localparam int IW = $clog2(QHW);

  hword_t [QHW-1:0] hw_q, hw_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic             skip_q, skip_d;
  logic             en;
  int               keep, wr_n, ofs, k, src;

  always_comb begin
    keep = int'(cnt_q) - int'(cons);
    ofs  = skip_q ? int'(wr_ofs) : 0;
    wr_n = wr_en ? (FHW - ofs) : 0;
    for (int j = 0; j < QHW; j++) begin
      k   = j + int'(cons);
      src = j - keep + ofs;
      if (k < int'(cnt_q))
        hw_d[j] = hw_q[k[IW-1:0]];
      else if ((j >= keep) && ((j - keep) < wr_n))
        hw_d[j] = wr_hw[src[FIW-1:0]];
      else
        hw_d[j] = '0;
    end
    cnt_d  = flush ? '0 : CNTW'(keep + wr_n);
    pc_d   = flush ? redirect_pc : pc_q + PC_W'({cons, 1'b0});
    skip_d = flush ? 1'b1 : (wr_en ? 1'b0 : skip_q);
    en     = flush || wr_en || (cons != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q   <= '0;
      cnt_q  <= '0;
      pc_q   <= '0;
      skip_q <= 1'b1;
    end else if (en) begin
      hw_q   <= hw_d;
      cnt_q  <= cnt_d;
      pc_q   <= pc_d;
      skip_q <= skip_d;
    end
  end

  assign hw_o   = hw_q;
  assign cnt_o  = cnt_q;
  assign pc_o   = pc_q;
  assign room_o = (cnt_q <= CNTW'(QHW - FHW));
endmodule

// File: rtl/ibq_slot.sv
module ibq_slot
  import ibq_pkg::*;
#(
  parameter int QHW  = 48,
  parameter int CNTW = $clog2(QHW + 1)
) (
  input  logic              cmp_mode,
  input  hword_t [QHW-1:0]  hw_i,
  input  logic [CNTW-1:0]   cnt_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              ok_i,
  input  logic [CNTW-1:0]   pos_i,
  output logic              ok_o,
  output logic [CNTW-1:0]   pos_o,
  output logic              wide_o,
  output logic [31:0]       insn_o,
  output logic [PC_W-1:0]   addr_o
);
  localparam int IW = $clog2(QHW);

  hword_t hw_a, hw_b;
  int     p, p1, need;
  logic   fits;

  always_comb begin
    p    = int'(pos_i);
    p1   = p + 1;
    hw_a = (p < QHW)  ? hw_i[p[IW-1:0]]  : '0;
    hw_b = (p1 < QHW) ? hw_i[p1[IW-1:0]] : '0;
    wide_o = starts_wide(cmp_mode, hw_a);
    need   = wide_o ? 2 : 1;
    fits   = ok_i && ((p + need) <= int'(cnt_i));
    ok_o   = fits;
    pos_o  = fits ? CNTW'(p + need) : pos_i;
    insn_o = wide_o ? {hw_b, hw_a} : {16'h0000, hw_a};
    addr_o = pc_i + PC_W'({pos_i, 1'b0});
  end
endmodule

// File: rtl/ibq_split.sv
module ibq_split
  import ibq_pkg::*;
#(
  parameter int QHW  = 48,
  parameter int NS   = 6,
  parameter int CNTW = $clog2(QHW + 1)
) (
  input  logic                     cmp_mode,
  input  hword_t [QHW-1:0]         hw_i,
  input  logic [CNTW-1:0]          cnt_i,
  input  logic [PC_W-1:0]          pc_i,
  output logic [NS-1:0]            valid_o,
  output logic [NS-1:0]            wide_o,
  output logic [NS-1:0][31:0]      insn_o,
  output logic [NS-1:0][PC_W-1:0]  addr_o,
  output logic [CNTW-1:0]          used_o
);
  logic [NS:0]           ok_c;
  logic [NS:0][CNTW-1:0] pos_c;

  assign ok_c[0]  = 1'b1;
  assign pos_c[0] = '0;

  for (genvar s = 0; s < NS; s++) begin : g_slot
    ibq_slot #(.QHW(QHW), .CNTW(CNTW)) u_slot (
      .cmp_mode (cmp_mode),
      .hw_i     (hw_i),
      .cnt_i    (cnt_i),
      .pc_i     (pc_i),
      .ok_i     (ok_c[s]),
      .pos_i    (pos_c[s]),
      .ok_o     (ok_c[s+1]),
      .pos_o    (pos_c[s+1]),
      .wide_o   (wide_o[s]),
      .insn_o   (insn_o[s]),
      .addr_o   (addr_o[s])
    );
    assign valid_o[s] = ok_c[s+1];
  end

  assign used_o = pos_c[NS];
endmodule

// File: rtl/insn_byte_queue.sv
module insn_byte_queue
  import ibq_pkg::*;
#(
  parameter int FETCH_BYTES = 48,
  parameter int QUEUE_BYTES = 96,
  parameter int SLOTS       = 6,
  localparam int FHW        = FETCH_BYTES / 2,
  localparam int QHW        = QUEUE_BYTES / 2,
  localparam int CNTW       = $clog2(QHW + 1),
  localparam int FIW        = $clog2(FHW)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [PC_W-1:0]          redirect_pc,
  input  logic                     cmp_mode,
  input  logic                     fetch_valid,
  output logic                     fetch_ready,
  input  logic [FETCH_BYTES*8-1:0] fetch_bytes,
  input  logic [FIW-1:0]           fetch_ofs,
  input  logic                     dec_ready,
  output logic [SLOTS-1:0]         dec_valid,
  output logic [SLOTS*32-1:0]      dec_insn,
  output logic [SLOTS*PC_W-1:0]    dec_addr,
  output logic [SLOTS-1:0]         dec_wide
);
  hword_t [FHW-1:0]          wr_hw;
  hword_t [QHW-1:0]          hw_st;
  logic [CNTW-1:0]           occ, used, cons;
  logic [PC_W-1:0]           head_pc;
  logic                      room, wr_en;
  logic [SLOTS-1:0][31:0]    insn_w;
  logic [SLOTS-1:0][PC_W-1:0] addr_w;

  for (genvar i = 0; i < FHW; i++) begin : g_hw
    assign wr_hw[i] = fetch_bytes[16*i +: 16];
  end

  assign wr_en       = fetch_valid && room && !flush;
  assign cons        = (dec_ready && !flush) ? used : '0;
  assign fetch_ready = room;

  ibq_store #(.QHW(QHW), .FHW(FHW), .CNTW(CNTW), .FIW(FIW)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .redirect_pc (redirect_pc),
    .wr_en       (wr_en),
    .wr_hw       (wr_hw),
    .wr_ofs      (fetch_ofs),
    .cons        (cons),
    .hw_o        (hw_st),
    .cnt_o       (occ),
    .pc_o        (head_pc),
    .room_o      (room)
  );

  ibq_split #(.QHW(QHW), .NS(SLOTS), .CNTW(CNTW)) u_split (
    .cmp_mode (cmp_mode),
    .hw_i     (hw_st),
    .cnt_i    (occ),
    .pc_i     (head_pc),
    .valid_o  (dec_valid),
    .wide_o   (dec_wide),
    .insn_o   (insn_w),
    .addr_o   (addr_w),
    .used_o   (used)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_out
    assign dec_insn[32*s +: 32]     = insn_w[s];
    assign dec_addr[PC_W*s +: PC_W] = addr_w[s];
  end
endmodule

// File: rtl/ibq_checker.sv
module ibq_checker
  import ibq_pkg::*;
#(
  parameter int SLOTS = 6,
  parameter int QHW   = 48,
  parameter int CNTW  = $clog2(QHW + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              cmp_mode,
  input logic              dec_ready,
  input logic              fetch_ready,
  input logic [SLOTS-1:0]  dec_valid,
  input logic [SLOTS-1:0]  dec_wide,
  input logic [31:0]       insn0,
  input logic [PC_W-1:0]   addr0,
  input logic [PC_W-1:0]   addr1,
  input logic [CNTW-1:0]   occ
);
  AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec_valid + 1'b1) & dec_valid) == '0); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid[1] |-> (addr1 == addr0 + (dec_wide[0] ? PC_W'(4) : PC_W'(2)))); // R5

  AST_FIXED_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_mode |-> ((dec_valid & ~dec_wide) == '0)); // R2

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((dec_valid == '0) && fetch_ready)); // R9

  AST_HOLD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_ready && !flush && dec_valid[0]) |=>
      (!$stable(cmp_mode) || (dec_valid[0] && $stable(insn0)))); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNTW'(QHW)); // R7
endmodule

bind insn_byte_queue ibq_checker #(.SLOTS(SLOTS), .QHW(QHW), .CNTW(CNTW)) u_ibq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .cmp_mode    (cmp_mode),
  .dec_ready   (dec_ready),
  .fetch_ready (fetch_ready),
  .dec_valid   (dec_valid),
  .dec_wide    (dec_wide),
  .insn0       (dec_insn[31:0]),
  .addr0       (dec_addr[31:0]),
  .addr1       (dec_addr[63:32]),
  .occ         (occ)
);

// File: tb/test_insn_byte_queue.sv
`timescale 1ns/1ps
module test_insn_byte_queue;
  localparam int FB  = 48;
  localparam int NS  = 6;
  localparam int FHW = FB / 2;
  localparam int QHW = 48;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              flush, cmp_mode, fetch_valid, dec_ready;
  logic [31:0]       redirect_pc;
  logic              fetch_ready;
  logic [FB*8-1:0]   fetch_bytes;
  logic [4:0]        fetch_ofs;
  logic [NS-1:0]     dec_valid, dec_wide;
  logic [NS*32-1:0]  dec_insn, dec_addr;

  always #2 clk = ~clk;

  insn_byte_queue i_insn_byte_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush), .redirect_pc(redirect_pc),
    .cmp_mode(cmp_mode), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_bytes(fetch_bytes), .fetch_ofs(fetch_ofs), .dec_ready(dec_ready),
    .dec_valid(dec_valid), .dec_insn(dec_insn), .dec_addr(dec_addr), .dec_wide(dec_wide)
  );

  int checks = 0;
  int fails  = 0;

  // reference queue
  logic [15:0] mq [0:QHW+FHW+2];
  int          mcnt;
  logic [31:0] mpc;
  bit          mskip;
  bit          ev [NS];
  bit          ew [NS];
  logic [31:0] ei [NS];
  logic [31:0] ea [NS];
  int          eused;
  logic [FB*8-1:0] blk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model_expect();
    int p = 0;
    bit ok = 1'b1;
    for (int s = 0; s < NS; s++) begin
      ev[s] = 1'b0; ew[s] = 1'b0; ei[s] = '0; ea[s] = '0;
      if (ok) begin
        logic [15:0] h = mq[p];
        bit w = !cmp_mode || (h[15:11] == 5'b11101) || (h[15:12] == 4'hF);
        int n = w ? 2 : 1;
        if (p + n <= mcnt) begin
          ev[s] = 1'b1; ew[s] = w;
          ei[s] = w ? {mq[p+1], h} : {16'h0000, h};
          ea[s] = mpc + 32'(2 * p);
          p += n;
        end else ok = 1'b0;
      end
    end
    eused = p;
  endfunction

  task automatic compare_all();
    logic [NS-1:0] evv;
    bit ok = 1'b1;
    string tag = cmp_mode ? "R3 R4 R5 R6" : "R2 R4 R5 R6";
    model_expect();
    for (int s = 0; s < NS; s++) evv[s] = ev[s];
    if (dec_valid !== evv) begin
      ok = 1'b0;
      chk(1'b0, tag, "valid", 64'(dec_valid), 64'(evv));
    end
    for (int s = 0; s < NS && ok; s++) begin
      if (ev[s]) begin
        if (dec_insn[32*s +: 32] !== ei[s]) begin
          ok = 1'b0; chk(1'b0, tag, $sformatf("insn slot%0d", s), 64'(dec_insn[32*s +: 32]), 64'(ei[s]));
        end else if (dec_addr[32*s +: 32] !== ea[s]) begin
          ok = 1'b0; chk(1'b0, tag, $sformatf("addr slot%0d", s), 64'(dec_addr[32*s +: 32]), 64'(ea[s]));
        end else if (dec_wide[s] !== ew[s]) begin
          ok = 1'b0; chk(1'b0, tag, $sformatf("wide slot%0d", s), 64'(dec_wide[s]), 64'(ew[s]));
        end
      end
    end
    if (ok) chk(1'b1, tag, "slots", 0, 0);
    chk(fetch_ready === (mcnt <= QHW - FHW), "R7", "fetch_ready",
        64'(fetch_ready), 64'(mcnt <= QHW - FHW));
  endtask

  // one cycle: drive at negedge, check, update model at posedge, then idle inputs
  task automatic step(input bit fv, input int ofs, input bit dr, input bit fl, input logic [31:0] rpc);
    bit acc;
    int used;
    @(negedge clk);
    fetch_valid = fv; fetch_ofs = 5'(ofs); dec_ready = dr; flush = fl;
    redirect_pc = rpc; fetch_bytes = blk;
    #1;
    compare_all();
    acc  = fv && (mcnt <= QHW - FHW);
    used = dr ? eused : 0;
    @(posedge clk);
    if (fl) begin
      mcnt = 0; mpc = rpc; mskip = 1'b1;
    end else begin
      for (int i = 0; i + used < mcnt; i++) mq[i] = mq[i+used];
      mcnt -= used;
      mpc  += 32'(2 * used);
      if (acc) begin
        for (int i = (mskip ? ofs : 0); i < FHW; i++) begin
          mq[mcnt] = blk[16*i +: 16];
          mcnt++;
        end
        mskip = 1'b0;
      end
    end
    #1;
    fetch_valid = 1'b0; dec_ready = 1'b0; flush = 1'b0;
  endtask

  task automatic peek();
    @(negedge clk); #1;
  endtask

  task automatic rand_block();
    for (int i = 0; i < FHW; i++) begin
      logic [15:0] h = 16'($urandom);
      if ($urandom % 3 == 0) h[15:13] = 3'b111;
      blk[16*i +: 16] = h;
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    int unsigned seed;
    logic [31:0] prev;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; flush = 1'b0; cmp_mode = 1'b0; fetch_valid = 1'b0;
    dec_ready = 1'b0; redirect_pc = '0; fetch_bytes = '0; fetch_ofs = '0; blk = '0;
    mcnt = 0; mpc = '0; mskip = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(dec_valid === '0, "R1", "valid after reset", 64'(dec_valid), 0);
    chk(fetch_ready === 1'b1, "R1", "fetch_ready after reset", 64'(fetch_ready), 1);
    rst_n = 1'b1;

    // fixed mode, first block after reset
    for (int i = 0; i < FHW; i++) blk[16*i +: 16] = 16'(16'h0101 * i + 16'h0010);
    step(1, 0, 0, 0, '0);
    peek();
    chk(dec_insn[31:0] === 32'h0111_0010, "R2", "fixed word", 64'(dec_insn[31:0]), 64'h0111_0010);
    chk(dec_valid === 6'b111111, "R6", "six slots", 64'(dec_valid), 64'h3f);
    chk(dec_addr[31:0] === 32'h0, "R1", "start address", 64'(dec_addr[31:0]), 0);
    step(0, 0, 1, 0, '0);
    peek();
    chk(dec_addr[31:0] === 32'd24, "R6", "slot0 after take", 64'(dec_addr[31:0]), 24);

    // compressed straddle after redirect with skip
    cmp_mode = 1'b1;
    step(0, 0, 0, 1, 32'h1000);
    peek();
    chk(dec_valid === '0 && fetch_ready === 1'b1, "R9", "empty after flush", 64'(dec_valid), 0);
    blk = '0;
    blk[16*22 +: 16] = 16'h1234;
    blk[16*23 +: 16] = 16'hE800;
    step(1, 22, 0, 0, '0);
    peek();
    chk(dec_valid === 6'b000001, "R4", "partial held", 64'(dec_valid), 1);
    chk(dec_insn[31:0] === 32'h0000_1234, "R10", "first kept hw", 64'(dec_insn[31:0]), 64'h1234);
    chk(dec_addr[31:0] === 32'h1000, "R10", "redirect address", 64'(dec_addr[31:0]), 64'h1000);
    for (int i = 0; i < FHW; i++) blk[16*i +: 16] = 16'h0001;
    blk[15:0] = 16'hBEEF;
    step(1, 5, 0, 0, '0);
    peek();
    chk(dec_insn[63:32] === 32'hBEEF_E800 && dec_wide[1] === 1'b1, "R4", "joined word",
        64'(dec_insn[63:32]), 64'hBEEF_E800);
    chk(dec_addr[63:32] === 32'h1002, "R5", "slot1 address", 64'(dec_addr[63:32]), 64'h1002);
    chk(dec_insn[95:64] === 32'h0000_0001, "R10", "later block unskipped", 64'(dec_insn[95:64]), 1);
    prev = dec_insn[31:0];
    peek();
    chk(dec_insn[31:0] === prev && dec_valid[0] === 1'b1, "R8", "hold while stalled",
        64'(dec_insn[31:0]), 64'(prev));
    step(0, 0, 1, 0, '0);
    peek();
    chk(dec_addr[31:0] === 32'h100E, "R6", "head after take", 64'(dec_addr[31:0]), 64'h100E);
    step(1, 0, 0, 0, '0);
    peek();
    chk(fetch_ready === 1'b0, "R7", "gated when full", 64'(fetch_ready), 0);
    step(1, 0, 1, 1, 32'h2000);
    peek();
    chk(dec_valid === '0 && fetch_ready === 1'b1, "R9", "flush drops write", 64'(dec_valid), 0);

    // random phases, alternating mode with a flush at each change
    for (int ph = 0; ph < 8; ph++) begin
      cmp_mode = ph[0];
      step(0, 0, 0, 1, 32'($urandom) & 32'hFFFF_FFFE);
      for (int c = 0; c < 500; c++) begin
        int ofs = int'($urandom % FHW);
        if (!cmp_mode) ofs = ofs & ~1;
        rand_block();
        step(($urandom % 4) != 0, ofs, ($urandom % 3) != 0, ($urandom % 100) == 0,
             32'($urandom) & 32'hFFFF_FFFE);
      end
    end
    finish_run();
  end
endmodule